// File: doc/BRIEF.md
# Threshold Bandwidth Byte Counter

This block measures traffic on one memory port by adding up the bytes carried on each valid beat while counting is switched on. A running count is compared with a programmable limit. Sticky interrupt status records that the limit was reached or that the count passed its top value. A single interrupt line is raised while any enabled status bit is set.

A build-time parameter picks one of two counting styles.

- **Rolling style:** the count runs freely past the limit and rolls over at its top value, which sets an overflow flag.
- **Wrapping style:** the count restarts each time it reaches the limit. Any bytes left over are kept, so software rebuilds the total as the count read plus the limit.

A small synchronous register port gives access to the following:

- the control word (run bit and a five-bit throttle field that is stored and driven out)
- a write-only count-zeroing command
- the count
- the limit
- the interrupt mask
- the status
- a write-one-to-clear command

Register offsets on `reg_addr`:

| Offset | Register |
|---|---|
| 0 | control |
| 1 | zero command |
| 2 | count |
| 3 | limit |
| 4 | interrupt mask |
| 5 | status |
| 6 | status clear |

Top module: `bw_byte_meter`

## Requirements
- R1: After a synchronous reset, the following are all zero: count, limit, run bit, throttle field, interrupt mask and status. `irq` is low and `reg_rdata` is zero.
- R2: While the run bit is 1, each cycle with `beat_valid` high adds `beat_bytes` to the count. While the run bit is 0, the count does not change and can still be read at offset 2.
- R3: Writing offset 1 with bit 0 set makes the count 0 on the next cycle. A beat arriving in the same cycle is dropped and raises no status. Writing offset 1 with bit 0 clear has no effect.
- R4: A write to offset 0 stores the run bit from bit 0 and the throttle field from bits 20:16. Both read back at those positions, and the throttle field is driven on `throttle_adj`. A write with bit 0 low stops counting and still stores the throttle bits written.
- R5: In rolling style (WRAP_MODE=0), a beat that moves the count from below a non-zero limit to at or above it sets status bit 0. The count keeps the full sum. A limit of 0 never sets bit 0.
- R6: In rolling style, a sum past 2^CNT_W-1 keeps only its low CNT_W bits and sets status bit 1.
- R7: In wrapping style (WRAP_MODE=1), with a non-zero limit, a beat whose sum is at or above the limit sets status bit 0 and leaves the count at sum minus limit. A sum below the limit that passes 2^CNT_W-1 sets status bit 1 and keeps the low CNT_W bits.
- R8: Status bits (bit 0 limit reached, bit 1 overflow) stay set until offset 6 is written with a 1 at the same position. An event arriving in the same cycle as its clear leaves the bit set.
- R9: `irq` is high exactly when the status and the interrupt mask (offset 4, bits 1:0, at the same positions as the status bits) share a set bit.
- R10: `reg_rdata` updates one cycle after a `reg_rd` cycle and shows register contents from before that edge. It is zero after any cycle without `reg_rd`, and zero for offset 7. Writes to offsets 2, 5 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| beat_valid | input | 1 | A beat is present this cycle |
| beat_bytes | input | BEAT_W | Byte count carried by the beat |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| throttle_adj | output | 5 | Stored throttle field |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds two copies with a 12-bit count and 8-bit beats, one in rolling style and one in wrapping style. Both copies are driven by the same stimulus. The narrow count makes roll-over reachable within about twenty full beats, so the overflow flag and its interaction with clears are exercised in both styles. Having both styles side by side exposes the difference between keeping the full sum and restarting at the limit, including the leftover bytes kept after a restart. A final pseudo-random phase mixes register writes with beats, which covers limits smaller than a single beat.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int ADDR_W  = 3;
  localparam int ST_W    = 2;
  localparam int ST_HIT  = 0;
  localparam int ST_OVF  = 1;
  localparam int THR_LSB = 16;
  localparam int THR_W   = 5;

  typedef enum logic [ADDR_W-1:0] {
    OFS_CTRL  = 3'd0,
    OFS_ZERO  = 3'd1,
    OFS_COUNT = 3'd2,
    OFS_LIMIT = 3'd3,
    OFS_IMASK = 3'd4,
    OFS_STAT  = 3'd5,
    OFS_SCLR  = 3'd6
  } ofs_e;
endpackage

// File: rtl/bwm_regfile.sv
module bwm_regfile
  import bwm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [ST_W-1:0]   status,
  output logic              run,
  output logic [THR_W-1:0]  throttle,
  output logic [CNT_W-1:0]  limit,
  output logic [ST_W-1:0]   imask,
  output logic              zero_req,
  output logic [ST_W-1:0]   stat_clr,
  output logic [DATA_W-1:0] rdata
);
  logic              run_q;
  logic [THR_W-1:0]  thr_q;
  logic [CNT_W-1:0]  lim_q;
  logic [ST_W-1:0]   msk_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rd_mux;

  logic hit_ctrl, hit_lim, hit_msk;
  assign hit_ctrl = wr && (addr == OFS_CTRL);
  assign hit_lim  = wr && (addr == OFS_LIMIT);
  assign hit_msk  = wr && (addr == OFS_IMASK);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      thr_q <= '0;
      lim_q <= '0;
      msk_q <= '0;
      rd_q  <= '0;
    end else begin
      if (hit_ctrl) begin
        run_q <= wdata[0];
        thr_q <= wdata[THR_LSB +: THR_W];
      end
      if (hit_lim) lim_q <= wdata[CNT_W-1:0];
      if (hit_msk) msk_q <= wdata[ST_W-1:0];
      rd_q <= rd ? rd_mux : '0;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      OFS_CTRL: begin
        rd_mux[0] = run_q;
        rd_mux[THR_LSB +: THR_W] = thr_q;
      end
      OFS_COUNT: rd_mux[CNT_W-1:0] = count;
      OFS_LIMIT: rd_mux[CNT_W-1:0] = lim_q;
      OFS_IMASK: rd_mux[ST_W-1:0]  = msk_q;
      OFS_STAT:  rd_mux[ST_W-1:0]  = status;
      default:   rd_mux = '0;
    endcase
  end

  assign zero_req = wr && (addr == OFS_ZERO) && wdata[0];
  assign stat_clr = (wr && (addr == OFS_SCLR)) ? wdata[ST_W-1:0] : '0;
  assign run      = run_q;
  assign throttle = thr_q;
  assign limit    = lim_q;
  assign imask    = msk_q;
  assign rdata    = rd_q;

  // R4: the run bit follows bit 0 of a control write
  a_r4_run_follows: assert property (@(posedge clk) disable iff (rst)
    hit_ctrl |=> run == $past(wdata[0]));
  // R10: no read strobe means zero read data
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd |=> rdata == '0);
endmodule

// File: rtl/bwm_counter.sv
module bwm_counter #(
  parameter int CNT_W     = 32,
  parameter int BEAT_W    = 8,
  parameter bit WRAP_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              beat_v,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic [CNT_W-1:0]  limit,
  input  logic              zero_req,
  output logic [CNT_W-1:0]  count,
  output logic              hit_evt,
  output logic              ovf_evt
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] lim_x;
  logic [SUM_W-1:0] rem;
  logic             adv;

  assign lim_x = {1'b0, limit};
  assign sum   = {1'b0, cnt_q} + {{(SUM_W-BEAT_W){1'b0}}, beat_bytes};
  assign rem   = sum - lim_x;
  assign adv   = run && beat_v && !zero_req;

  generate
    if (WRAP_MODE) begin : g_wrap
      assign hit_evt = adv && (limit != '0) && (sum >= lim_x);
      assign ovf_evt = adv && !hit_evt && sum[CNT_W];
      assign cnt_nxt = hit_evt ? rem[CNT_W-1:0] : sum[CNT_W-1:0];
    end else begin : g_roll
      assign hit_evt = adv && ({1'b0, cnt_q} < lim_x) && (sum >= lim_x);
      assign ovf_evt = adv && sum[CNT_W];
      assign cnt_nxt = sum[CNT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= '0;
    else if (zero_req) cnt_q <= '0;
    else if (adv)      cnt_q <= cnt_nxt;
  end

  assign count = cnt_q;

  // R3: a zero command empties the count on the next cycle
  a_r3_zeroed: assert property (@(posedge clk) disable iff (rst)
    zero_req |=> count == '0);
  // R2: no accepted beat and no zero command keeps the count
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!zero_req && !(run && beat_v)) |=> $stable(count));
  // R2: a plain beat adds its bytes
  a_r2_add: assert property (@(posedge clk) disable iff (rst)
    (adv && !hit_evt && !ovf_evt) |=>
      count == $past(cnt_q) + {{(CNT_W-BEAT_W){1'b0}}, $past(beat_bytes)});
endmodule

// File: rtl/bwm_irq.sv
module bwm_irq
  import bwm_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] set_vec,
  input  logic [ST_W-1:0] clr_vec,
  input  logic [ST_W-1:0] imask,
  output logic [ST_W-1:0] status,
  output logic            irq
);
  logic [ST_W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= (st_q & ~clr_vec) | set_vec;
  end

  assign status = st_q;
  assign irq    = |(st_q & imask);

  generate
    for (genvar i = 0; i < ST_W; i++) begin : g_chk
      // R8: a set bit stays set unless cleared
      a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (st_q[i] && !clr_vec[i]) |=> st_q[i]);
      // R8: an event wins over a clear in the same cycle
      a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_vec[i] |=> st_q[i]);
    end
  endgenerate
endmodule

// File: rtl/bw_byte_meter.sv
module bw_byte_meter
  import bwm_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int BEAT_W    = 8,
  parameter bit WRAP_MODE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat_valid,
  input  logic [BEAT_W-1:0] beat_bytes,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [4:0]        throttle_adj,
  output logic              irq
);
  logic              run;
  logic [CNT_W-1:0]  limit;
  logic [CNT_W-1:0]  count;
  logic [ST_W-1:0]   imask;
  logic [ST_W-1:0]   status;
  logic [ST_W-1:0]   stat_clr;
  logic [ST_W-1:0]   set_vec;
  logic              zero_req;
  logic              hit_evt;
  logic              ovf_evt;

  bwm_regfile #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr       (reg_wr),
    .rd       (reg_rd),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .count    (count),
    .status   (status),
    .run      (run),
    .throttle (throttle_adj),
    .limit    (limit),
    .imask    (imask),
    .zero_req (zero_req),
    .stat_clr (stat_clr),
    .rdata    (reg_rdata)
  );

  bwm_counter #(.CNT_W(CNT_W), .BEAT_W(BEAT_W), .WRAP_MODE(WRAP_MODE)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .beat_v     (beat_valid),
    .beat_bytes (beat_bytes),
    .limit      (limit),
    .zero_req   (zero_req),
    .count      (count),
    .hit_evt    (hit_evt),
    .ovf_evt    (ovf_evt)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[ST_HIT] = hit_evt;
    set_vec[ST_OVF] = ovf_evt;
  end

  bwm_irq u_irq (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (stat_clr),
    .imask   (imask),
    .status  (status),
    .irq     (irq)
  );

  // R6: an overflow event in rolling style always sets status bit 1
  a_r6_ovf_flag: assert property (@(posedge clk) disable iff (rst)
    (ovf_evt && !WRAP_MODE) |=> status[ST_OVF]);
  // R7: a restart in wrapping style leaves less than one limit in the count
  a_r7_wrap_rem: assert property (@(posedge clk) disable iff (rst)
    (WRAP_MODE && hit_evt && ({1'b0, count} + beat_bytes < 2 * {1'b0, limit}))
      |=> count < $past(limit));
endmodule

// File: tb/bw_byte_meter_tb_top.sv
module bw_byte_meter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;
  localparam int BW = 8;
  localparam int DW = 32;
  localparam longint CMASK = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic beat_valid = 1'b0;
  logic [BW-1:0] beat_bytes = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] rdata_r, rdata_w;
  logic [4:0] thr_r, thr_w;
  logic irq_r, irq_w;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  bit started = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bw_byte_meter #(.DATA_W(DW), .CNT_W(CW), .BEAT_W(BW), .WRAP_MODE(1'b0)) dut_i (
    .clk(clk), .rst(rst), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_r), .throttle_adj(thr_r), .irq(irq_r));

  bw_byte_meter #(.DATA_W(DW), .CNT_W(CW), .BEAT_W(BW), .WRAP_MODE(1'b1)) dut_w (
    .clk(clk), .rst(rst), .beat_valid(beat_valid), .beat_bytes(beat_bytes),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(rdata_w), .throttle_adj(thr_w), .irq(irq_w));

  // reference model: index 0 rolling style, index 1 wrapping style
  longint m_cnt [2];
  logic [1:0] m_st [2];
  longint m_rd [2];
  bit m_run;
  longint m_thr, m_lim;
  logic [1:0] m_ien;

  function automatic longint model_read(int k, logic [2:0] a);
    case (a)
      3'd0: return (m_thr << 16) | longint'(m_run);
      3'd2: return m_cnt[k];
      3'd3: return m_lim;
      3'd4: return longint'(m_ien);
      3'd5: return longint'(m_st[k]);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] = 0; m_st[k] = 2'b00; m_rd[k] = 0;
      end
      m_run = 1'b0; m_thr = 0; m_lim = 0; m_ien = 2'b00;
    end else begin
      bit zero;
      logic [1:0] clrm;
      zero = reg_wr && reg_addr == 3'd1 && reg_wdata[0];
      clrm = (reg_wr && reg_addr == 3'd6) ? reg_wdata[1:0] : 2'b00;
      for (int k = 0; k < 2; k++) begin
        logic [1:0] setm;
        longint sum;
        m_rd[k] = reg_rd ? model_read(k, reg_addr) : 0;
        setm = 2'b00;
        if (zero) m_cnt[k] = 0;
        else if (m_run && beat_valid) begin
          sum = m_cnt[k] + longint'(beat_bytes);
          if (k == 0) begin
            if (m_cnt[k] < m_lim && sum >= m_lim) setm[0] = 1'b1;
            if (sum > CMASK) setm[1] = 1'b1;
            m_cnt[k] = sum & CMASK;
          end else if (m_lim != 0 && sum >= m_lim) begin
            setm[0] = 1'b1;
            m_cnt[k] = (sum - m_lim) & CMASK;
          end else begin
            if (sum > CMASK) setm[1] = 1'b1;
            m_cnt[k] = sum & CMASK;
          end
        end
        m_st[k] = (m_st[k] & ~clrm) | setm;
      end
      if (reg_wr && reg_addr == 3'd0) begin
        m_run = reg_wdata[0];
        m_thr = longint'(reg_wdata[20:16]);
      end
      if (reg_wr && reg_addr == 3'd3) m_lim = longint'(reg_wdata) & CMASK;
      if (reg_wr && reg_addr == 3'd4) m_ien = reg_wdata[1:0];
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(cur_req, "rdata rolling", longint'(rdata_r), m_rd[0]);
      chk(cur_req, "rdata wrapping", longint'(rdata_w), m_rd[1]);
      chk(cur_req, "irq rolling", longint'(irq_r), longint'(|(m_st[0] & m_ien)));
      chk(cur_req, "irq wrapping", longint'(irq_w), longint'(|(m_st[1] & m_ien)));
      chk(cur_req, "throttle rolling", longint'(thr_r), m_thr);
      chk(cur_req, "throttle wrapping", longint'(thr_w), m_thr);
    end
  end

  task automatic cyc(input bit v, input int b, input bit w, input bit r,
                     input int a, input longint d);
    @(negedge clk); #1;
    beat_valid = v; beat_bytes = BW'(b);
    reg_wr = w; reg_rd = r; reg_addr = 3'(a); reg_wdata = DW'(d);
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask
  task automatic wr(input int a, input longint d); cyc(0, 0, 1, 0, a, d); endtask
  task automatic rd(input int a); cyc(0, 0, 0, 1, a, 0); endtask
  task automatic beat(input int b); cyc(1, b, 0, 0, 0, 0); endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    repeat (3) idle();
    @(negedge clk); #1; rst = 1'b0;
    cur_req = "R1";
    for (int a = 0; a < 8; a++) rd(a);
    idle();
    chk("R1", "irq after reset", longint'(irq_r | irq_w), 0);

    cur_req = "R4";
    wr(0, 64'h000A_0001); rd(0); idle();

    cur_req = "R2";
    beat(10); beat(20); beat(255); rd(2);
    cyc(1, 40, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0);
    wr(0, 64'h000A_0000); beat(50); beat(50); rd(2); rd(0); idle();

    cur_req = "R3";
    wr(0, 1); beat(5); cyc(1, 100, 1, 0, 1, 1); rd(2);
    beat(7); cyc(0, 0, 1, 0, 1, 2); rd(2); idle();

    cur_req = "R5";
    wr(1, 1); wr(3, 100); wr(4, 3); beat(60); rd(5); beat(60); rd(2); rd(5); idle();
    cur_req = "R7";
    beat(90); rd(2); rd(5); idle();

    cur_req = "R8";
    cyc(1, 200, 1, 0, 6, 1); rd(5); wr(6, 3); rd(5); wr(6, 1); rd(5); idle();

    cur_req = "R9";
    beat(150); wr(4, 2); idle(); wr(4, 1); idle(); wr(4, 0); idle(); wr(4, 3); wr(6, 3); idle();

    cur_req = "R6";
    wr(1, 1); wr(3, 0);
    for (int i = 0; i < 20; i++) beat(255);
    rd(2); rd(5); wr(6, 2); rd(5); idle();

    cur_req = "R10";
    wr(2, 64'h55); wr(5, 3); wr(7, 64'hFFFF_FFFF); rd(2); rd(5); rd(7); rd(3); idle();

    cur_req = "mixed R2 R5 R6 R7 R8";
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = int'($urandom % 16);
      if (sel < 2) cyc($urandom % 2, $urandom % 256, 1, 0, $urandom % 8, longint'($urandom));
      else if (sel == 2) cyc(1, $urandom % 256, 1, 0, 0, 64'h1 | (longint'($urandom % 32) << 16));
      else if (sel == 3) cyc(1, $urandom % 256, 1, 0, 3, 64 + longint'($urandom % 2000));
      else cyc($urandom % 4 != 0, $urandom % 256, 0, 1, $urandom % 8, 0);
    end
    idle(); idle();
    finish_run();
  end
endmodule